// File: doc/BRIEF.md
# Bidirectional Pad Routing Multiplexer

This block joins one physical bidirectional pad to one of several peripheral pin interfaces. Each peripheral presents three signals: a drive value, a drive enable and a receive value. The pad side carries the same three signals. A select input picks one peripheral. That peripheral's drive value and drive enable go out to the pad, and the pad's receive value comes back to that peripheral alone. Every other peripheral sees a steady low on its receive input.

The routing is purely combinational. A new select value, or any change on a routed signal, shows up at the outputs after gate delay only, with no clock edge involved. The number of peripheral ports is a parameter, and the select width is derived from it. When the select holds a value past the last port, the pad is left undriven and no peripheral receives anything. A stray select code therefore cannot switch the pad on. The tristate cell itself sits outside this block and consumes the pad-side drive value and drive enable.

Top module: `pad_route_mux`

## Requirements
- R1: When the select value `sel` is below NUM_PORTS, `pad_out` equals bit `sel` of `periph_out` and follows every change of that bit.
- R2: When `sel` is below NUM_PORTS, `pad_drv_en` equals bit `sel` of `periph_drv_en` and follows every change of that bit.
- R3: When `sel` is below NUM_PORTS, bit `sel` of `periph_in` equals `pad_in`.
- R4: Every bit of `periph_in` whose index differs from `sel` is 0, whatever the value of `pad_in`.
- R5: Changes on `sel` or on any routed input reach the outputs with no clock edge in between.
- R6: A `sel` value of NUM_PORTS or more drives `pad_out` and `pad_drv_en` to 0 and holds all of `periph_in` at 0.
- R7: At most one bit of `periph_in` is 1 at any time.
- R8: When `sel` moves away from a port, that port's `periph_in` bit returns to 0 at once, even while `pad_in` stays 1.
- R9: The select width is ceil(log2(NUM_PORTS)), with a minimum of 1 bit. NUM_PORTS must be at least 2. With NUM_PORTS = 2 the select is one bit wide, and both of its values route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel | input | SEL_W | Index of the peripheral connected to the pad |
| periph_out | input | NUM_PORTS | Drive value from each peripheral |
| periph_drv_en | input | NUM_PORTS | Drive enable from each peripheral |
| periph_in | output | NUM_PORTS | Receive value delivered to each peripheral |
| pad_in | input | 1 | Value received from the pad |
| pad_out | output | 1 | Drive value sent to the pad |
| pad_drv_en | output | 1 | Drive enable sent to the pad |

## Verification
The bench visits every port in a shuffled order. Before and after each selection it parks the select on other ports, so that a design which latched the pad value or left a stale port connected would show a 1 on a port that is no longer chosen. It sets the select to unused codes while every peripheral drives and enables, which catches a decoder that wraps or truncates the index and would switch the pad on by mistake. Every check is sampled within the same half clock period as the stimulus, so any hidden register shows up as a stale output. A second instance with two ports exercises the single-bit select, where an off-by-one in the width rule would drop one port.

// File: rtl/pad_route_pkg.sv
package pad_route_pkg;

   // Select width for n ports: ceil(log2(n)), never below one bit.
   function automatic int sel_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/prw_sel_decode.sv
module prw_sel_decode #(
   parameter int N     = 5,
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0] sel,
   output logic [N-1:0]     onehot,
   output logic             in_range
);

   localparam int CODES = 1 << SEL_W;

   if (N < 2) begin : g_bad_n
      $error("prw_sel_decode: N must be at least 2");
   end
   if (CODES < N) begin : g_bad_w
      $error("prw_sel_decode: SEL_W too narrow for N");
   end

   // A fully populated code space needs no range compare.
   if (CODES == N) begin : g_full
      assign in_range = 1'b1;
   end else begin : g_ranged
      assign in_range = (int'(sel) < N);
   end

   for (genvar k = 0; k < N; k++) begin : g_dec
      assign onehot[k] = (sel == SEL_W'(k));
   end

   always_comb begin
      assert_onehot_R7: assert ($onehot0(onehot))
         else $error("decoder selected more than one port");
      if (!in_range) begin
         assert_no_pick_R6: assert (onehot == '0)
            else $error("out-of-range select picked a port");
      end
   end

endmodule

// File: rtl/prw_out_gather.sv
module prw_out_gather #(
   parameter int N = 5
) (
   input  logic [N-1:0] onehot,
   input  logic [N-1:0] periph_out,
   input  logic [N-1:0] periph_drv_en,
   output logic         pad_out,
   output logic         pad_drv_en
);

   // AND-OR gather: an all-zero one-hot yields an idle pad.
   assign pad_out    = |(periph_out    & onehot);
   assign pad_drv_en = |(periph_drv_en & onehot);

endmodule

// File: rtl/prw_in_scatter.sv
module prw_in_scatter #(
   parameter int N = 5
) (
   input  logic [N-1:0] onehot,
   input  logic         pad_in,
   output logic [N-1:0] periph_in
);

   for (genvar k = 0; k < N; k++) begin : g_port
      assign periph_in[k] = onehot[k] & pad_in;
   end

endmodule

// File: rtl/pad_route_mux.sv
module pad_route_mux
   import pad_route_pkg::*;
#(
   parameter  int NUM_PORTS = 5,
   localparam int SEL_W     = sel_width(NUM_PORTS)
) (
   input  logic [SEL_W-1:0]     sel,
   input  logic [NUM_PORTS-1:0] periph_out,
   input  logic [NUM_PORTS-1:0] periph_drv_en,
   output logic [NUM_PORTS-1:0] periph_in,
   input  logic                 pad_in,
   output logic                 pad_out,
   output logic                 pad_drv_en
);

   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("pad_route_mux: NUM_PORTS must be at least 2");
   end

   logic [NUM_PORTS-1:0] onehot;
   logic                 in_range;

   prw_sel_decode #(.N(NUM_PORTS), .SEL_W(SEL_W)) u_dec (
      .sel      (sel),
      .onehot   (onehot),
      .in_range (in_range)
   );

   prw_out_gather #(.N(NUM_PORTS)) u_out (
      .onehot        (onehot),
      .periph_out    (periph_out),
      .periph_drv_en (periph_drv_en),
      .pad_out       (pad_out),
      .pad_drv_en    (pad_drv_en)
   );

   prw_in_scatter #(.N(NUM_PORTS)) u_in (
      .onehot    (onehot),
      .pad_in    (pad_in),
      .periph_in (periph_in)
   );

   always_comb begin
      for (int k = 0; k < NUM_PORTS; k++) begin
         if (int'(sel) == k) begin
            assert_pad_out_R1: assert (pad_out == periph_out[k])
               else $error("pad_out does not follow the selected port");
            assert_pad_en_R2: assert (pad_drv_en == periph_drv_en[k])
               else $error("pad_drv_en does not follow the selected port");
            assert_sel_in_R3: assert (periph_in[k] == pad_in)
               else $error("selected port does not see pad_in");
         end else begin
            assert_unsel_zero_R4: assert (periph_in[k] == 1'b0)
               else $error("unselected port sees a nonzero input");
         end
      end
      if (int'(sel) >= NUM_PORTS) begin
         assert_idle_pad_R6: assert (!pad_out && !pad_drv_en && periph_in == '0)
            else $error("out-of-range select left the pad active");
      end
      assert_single_in_R7: assert ($countones(periph_in) <= 1)
         else $error("several ports receive at once");
   end

endmodule

// File: tb/pad_route_mux_bench.sv
module pad_route_mux_bench;

   localparam int N  = 5;
   localparam int SW = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   int checks = 0;
   int errors = 0;

   logic [SW-1:0] sel   = '0;
   logic [N-1:0]  p_out = '0;
   logic [N-1:0]  p_en  = '0;
   logic [N-1:0]  p_in;
   logic          pad_in = 1'b0;
   logic          pad_out, pad_en;

   pad_route_mux #(.NUM_PORTS(N)) u_pad_route_mux (
      .sel (sel), .periph_out (p_out), .periph_drv_en (p_en),
      .periph_in (p_in), .pad_in (pad_in),
      .pad_out (pad_out), .pad_drv_en (pad_en)
   );

   logic       sel2 = 1'b0;
   logic [1:0] out2 = '0, en2 = '0, in2;
   logic       pin2 = 1'b0, pout2, pen2;

   pad_route_mux #(.NUM_PORTS(2)) u_pad_route_mux_two (
      .sel (sel2), .periph_out (out2), .periph_drv_en (en2),
      .periph_in (in2), .pad_in (pin2),
      .pad_out (pout2), .pad_drv_en (pen2)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Stimulus table: {sel[2:0], out[4:0], en[4:0], pad_in}
   localparam int NV = 8;
   localparam logic [13:0] VEC [NV] = '{
      {3'd0, 5'b00001, 5'b00001, 1'b1},
      {3'd1, 5'b11101, 5'b00010, 1'b0},
      {3'd2, 5'b00100, 5'b11011, 1'b1},
      {3'd3, 5'b10111, 5'b01000, 1'b1},
      {3'd4, 5'b10000, 5'b10000, 1'b1},
      {3'd5, 5'b11111, 5'b11111, 1'b1},
      {3'd7, 5'b11111, 5'b11111, 1'b1},
      {3'd4, 5'b01111, 5'b01111, 1'b1}
   };

   // Apply at a falling edge, sample 1 ns later: no rising edge between (R5).
   task automatic apply(input logic [SW-1:0] s, input logic [N-1:0] o,
                        input logic [N-1:0] e, input logic pi);
      @(negedge clk);
      sel = s; p_out = o; p_en = e; pad_in = pi;
      #1;
   endtask

   localparam int ORDER [N] = '{3, 0, 4, 1, 2};

   initial begin
      // Idle state with all inputs low
      #1;
      check("R6 idle pad_out", pad_out, 0);
      check("R4 idle periph_in", p_in, 0);

      for (int v = 0; v < NV; v++) begin
         logic [SW-1:0] s;
         logic [N-1:0]  o, e;
         logic          pi;
         {s, o, e, pi} = VEC[v];
         apply(s, o, e, pi);
         if (int'(s) < N) begin
            check("R1 R5 pad_out", pad_out, o[s]);
            check("R2 R5 pad_drv_en", pad_en, e[s]);
            check("R3 R4 periph_in", p_in, int'(pi) << s);
         end else begin
            check("R6 pad_out", pad_out, 0);
            check("R6 pad_drv_en", pad_en, 0);
            check("R6 periph_in", p_in, 0);
         end
         check("R7 single input", $countones(p_in) <= 1, 1);
      end

      // Shuffled walk with distinct previous and next selects
      for (int i = 0; i < N; i++) begin
         int p, pv, nx;
         p  = ORDER[i];
         pv = (p + 2) % N;
         nx = (p + 3) % N;
         apply(SW'(pv), '0, '0, 1'b1);
         check("R4 port before select", p_in[p], 0);
         apply(SW'(p), '0, '0, 1'b1);
         check("R3 port selected", p_in[p], 1);
         check("R1 pad_out low", pad_out, 0);
         check("R2 pad_drv_en low", pad_en, 0);
         apply(SW'(p), N'(1) << p, '0, 1'b1);
         check("R1 R5 pad_out follows", pad_out, 1);
         apply(SW'(p), N'(1) << p, N'(1) << p, 1'b1);
         check("R2 R5 pad_drv_en follows", pad_en, 1);
         apply(SW'(p), N'(1) << p, N'(1) << p, 1'b0);
         check("R3 port follows pad low", p_in[p], 0);
         apply(SW'(nx), N'(1) << p, N'(1) << p, 1'b1);
         check("R8 port dropped after deselect", p_in[p], 0);
         check("R4 R8 only next port", p_in, 1 << nx);
      end

      // Out-of-range with everything driven and pad high
      apply(3'd6, '1, '1, 1'b1);
      check("R6 code 6 pad_out", pad_out, 0);
      check("R6 code 6 pad_drv_en", pad_en, 0);
      check("R6 code 6 periph_in", p_in, 0);

      // Two-port instance: one-bit select, both codes route
      @(negedge clk);
      sel2 = 1'b0; out2 = 2'b10; en2 = 2'b01; pin2 = 1'b1;
      #1;
      check("R9 two-port sel 0 out", pout2, 0);
      check("R9 two-port sel 0 en", pen2, 1);
      check("R9 two-port sel 0 in", in2, 1);
      @(negedge clk);
      sel2 = 1'b1;
      #1;
      check("R9 two-port sel 1 out", pout2, 1);
      check("R9 two-port sel 1 en", pen2, 0);
      check("R9 two-port sel 1 in", in2, 2);
      check("R9 select width", $bits(sel2), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule